// File: doc/BRIEF.md
# MSI-X Vector Table and Pending Controller

This block is the interrupt side of an MSI-X function with `NVEC` vectors. It holds a word-addressed vector table. Each entry has a 64-bit message address, a 32-bit message data word and a control word that carries the per-vector mask. It also holds the pending-bit array, which software can only read, and the enable and function-mask bits of the message-control word. Device logic raises interrupt requests by vector index. The block turns each accepted request into one address/data message write on a valid/ready output.

A request to a masked vector is held as a pending bit. When the vector's effective mask later clears, the request is delivered automatically. The effective mask can clear through a per-vector unmask, through clearing the function mask, or through enabling the function. Device logic also declares vectors in use or no longer in use, and requests to unused vectors are discarded. The table and pending-array port is 32 bits wide. An 8-byte access arrives as two consecutive word accesses, low word first.

Top module: `msix_unit`

## Requirements
- R1: Table word `4*v+0` holds the low half of vector v's message address, word `4*v+1` the high half, word `4*v+2` the message data, and word `4*v+3` the control word. The mask is control bit 0, and the other control bits read as zero.
- R2: With `reg_pba` high, word k reads pending bits of vectors 32k..32k+31, vector v at bit v mod 32, so byte v/8 bit v mod 8. Writes there change nothing.
- R3: `cfg_rdata` reads enable at bit 15, function mask at bit 14, zeros in bits 13:11 and `NVEC-1` in bits 10:0. A `cfg_we` write loads bits 15 and 14 from `cfg_wdata`.
- R4: A request whose index is `NVEC` or more, or whose vector has a use count of zero, produces no message and sets no pending bit.
- R5: A request to a vector that is not effectively masked produces one message carrying that entry's address and data.
- R6: A vector is effectively masked when its mask bit is set, the function mask is set, or enable is clear. A request to such a vector sets its pending bit and sends nothing.
- R7: When a pending vector becomes unmasked by any of the three causes, its pending bit clears and its message is sent once.
- R8: After reset, enable and function mask are clear, every address and data word is zero, no pending bit is set and every mask bit is set.
- R9: `use_cmd` increments a vector's count and `unuse_cmd` decrements it. When the count reaches zero the pending bit clears. An unuse of an out-of-range vector or a vector with count zero is ignored.
- R10: Several vectors released together are sent in ascending index order, one per accepted handshake.
- R11: Message address and data are taken from the table when the message is issued. While `msg_valid` is high and `msg_ready` is low, they and `msg_valid` stay unchanged.
- R12: `intx_out` follows `intx_in` while enable is clear and is held low while enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for the message-control word |
| cfg_wdata | input | 16 | Message-control write value |
| cfg_rdata | output | 16 | Message-control read value |
| reg_wr | input | 1 | Word write strobe for table or pending array |
| reg_pba | input | 1 | 1 selects the pending array, 0 the table |
| reg_addr | input | $clog2(4*NVEC) | Word address within the selected region |
| reg_wdata | input | 32 | Write word |
| reg_rdata | output | 32 | Read word, combinational from address |
| irq_req | input | 1 | Interrupt request strobe |
| irq_vec | input | $clog2(NVEC)+1 | Requested vector index |
| use_cmd | input | 1 | Increment use count of `use_vec` |
| unuse_cmd | input | 1 | Decrement use count of `use_vec` |
| use_vec | input | $clog2(NVEC)+1 | Vector for use/unuse |
| msg_valid | output | 1 | Message write valid |
| msg_ready | input | 1 | Message write accepted |
| msg_addr | output | 64 | Message address |
| msg_data | output | 32 | Message data |
| intx_in | input | 1 | Legacy interrupt from device logic |
| intx_out | output | 1 | Legacy interrupt toward the link |

## Verification
The embedded properties check four things on every cycle. A stalled message holds its address, data and valid. A message only starts while the function is enabled and unmasked. A pending bit never stays set on an unmasked vector for more than one cycle, and no vector with a zero use count carries a pending bit. They also check the mask and pending state right after reset. The bench scenarios are needed for the rest. They show which table entry a message comes from, the ascending release order after a function-mask clear, and the exact pending-array bit layout. They also show that writes to the pending array have no effect, and that an ignored unuse keeps the count from wrapping.

// File: rtl/msix_unit.sv
module msix_unit #(
  parameter int NVEC = 8,
  parameter int CNTW = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_we,
  input  logic [15:0]                 cfg_wdata,
  output logic [15:0]                 cfg_rdata,
  input  logic                        reg_wr,
  input  logic                        reg_pba,
  input  logic [$clog2(4*NVEC)-1:0]   reg_addr,
  input  logic [31:0]                 reg_wdata,
  output logic [31:0]                 reg_rdata,
  input  logic                        irq_req,
  input  logic [$clog2(NVEC):0]       irq_vec,
  input  logic                        use_cmd,
  input  logic                        unuse_cmd,
  input  logic [$clog2(NVEC):0]       use_vec,
  output logic                        msg_valid,
  input  logic                        msg_ready,
  output logic [63:0]                 msg_addr,
  output logic [31:0]                 msg_data,
  input  logic                        intx_in,
  output logic                        intx_out
);
  localparam int IW = $clog2(NVEC);
  localparam int VW = IW + 1;
  localparam int AW = $clog2(4*NVEC);
  localparam int PW = (NVEC + 31) / 32;

  logic [31:0]      a_lo [NVEC];
  logic [31:0]      a_hi [NVEC];
  logic [31:0]      m_dat [NVEC];
  logic [CNTW-1:0]  cnt [NVEC];
  logic [CNTW-1:0]  cnt_nx [NVEC];
  logic [NVEC-1:0]  vmask, pend, snd, pend_nx, snd_nx, drop, m_eff, cand;
  logic             cfg_en, cfg_fm, fmask, issue, irq_ok;
  logic [IW-1:0]    sel, irq_idx, vi;
  logic [PW*32-1:0] pba_flat;
  logic [13:0]      unused_cfg_bits;

  assign unused_cfg_bits = cfg_wdata[13:0];
  assign fmask     = ~cfg_en | cfg_fm;
  assign m_eff     = vmask | {NVEC{fmask}};
  assign cand      = snd & ~m_eff;
  assign issue     = (|cand) & (~msg_valid | msg_ready);
  assign irq_idx   = irq_vec[IW-1:0];
  assign irq_ok    = irq_req && (irq_vec < VW'(NVEC)) && (cnt[irq_idx] != '0);
  assign vi        = reg_addr[AW-1:2];
  assign pba_flat  = (PW*32)'(pend);
  assign cfg_rdata = {cfg_en, cfg_fm, 3'b000, 11'(NVEC-1)};
  assign intx_out  = intx_in & ~cfg_en;

  always_comb begin
    sel = '0;
    for (int i = NVEC-1; i >= 0; i--)
      if (cand[i]) sel = IW'(i);
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_pba) begin
      if (reg_addr < AW'(PW)) reg_rdata = pba_flat[{reg_addr, 5'd0} +: 32];
    end else if (int'(vi) < NVEC) begin
      case (reg_addr[1:0])
        2'd0: reg_rdata = a_lo[vi];
        2'd1: reg_rdata = a_hi[vi];
        2'd2: reg_rdata = m_dat[vi];
        default: reg_rdata = {31'd0, vmask[vi]};
      endcase
    end
  end

  always_comb begin
    drop = '0;
    for (int v = 0; v < NVEC; v++) begin
      cnt_nx[v] = cnt[v];
      if (use_cmd && use_vec == VW'(v)) begin
        if (cnt[v] != '1) cnt_nx[v] = cnt[v] + 1'b1;
      end else if (unuse_cmd && use_vec == VW'(v) && cnt[v] != '0) begin
        cnt_nx[v] = cnt[v] - 1'b1;
        drop[v]   = (cnt[v] == CNTW'(1));
      end
    end
  end

  always_comb begin
    pend_nx = pend;
    snd_nx  = snd;
    if (issue) snd_nx[sel] = 1'b0;
    if (irq_ok) begin
      if (m_eff[irq_idx]) pend_nx[irq_idx] = 1'b1;
      else                snd_nx[irq_idx]  = 1'b1;
    end
    for (int v = 0; v < NVEC; v++) begin
      if (snd_nx[v] && m_eff[v]) begin
        snd_nx[v]  = 1'b0;
        pend_nx[v] = 1'b1;
      end else if (pend_nx[v] && !m_eff[v]) begin
        pend_nx[v] = 1'b0;
        snd_nx[v]  = 1'b1;
      end
      if (drop[v]) begin
        pend_nx[v] = 1'b0;
        snd_nx[v]  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_en <= 1'b0;
      cfg_fm <= 1'b0;
      vmask  <= '1;
      pend   <= '0;
      snd    <= '0;
      for (int v = 0; v < NVEC; v++) begin
        a_lo[v]  <= '0;
        a_hi[v]  <= '0;
        m_dat[v] <= '0;
        cnt[v]   <= '0;
      end
    end else begin
      if (cfg_we) begin
        cfg_en <= cfg_wdata[15];
        cfg_fm <= cfg_wdata[14];
      end
      if (reg_wr && !reg_pba && int'(vi) < NVEC) begin
        case (reg_addr[1:0])
          2'd0: a_lo[vi]  <= reg_wdata;
          2'd1: a_hi[vi]  <= reg_wdata;
          2'd2: m_dat[vi] <= reg_wdata;
          default: vmask[vi] <= reg_wdata[0];
        endcase
      end
      pend <= pend_nx;
      snd  <= snd_nx;
      for (int v = 0; v < NVEC; v++) cnt[v] <= cnt_nx[v];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msg_valid <= 1'b0;
      msg_addr  <= '0;
      msg_data  <= '0;
    end else begin
      msg_valid <= issue | (msg_valid & ~msg_ready);
      if (issue) begin
        msg_addr <= {a_hi[sel], a_lo[sel]};
        msg_data <= m_dat[sel];
      end
    end
  end

  logic [NVEC-1:0] zero_cnt;
  always_comb
    for (int v = 0; v < NVEC; v++) zero_cnt[v] = (cnt[v] == '0);

  a_r11_msg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));

  a_r6_no_send_when_fmasked: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_valid) |-> $past(cfg_en && !cfg_fm));

  a_r7_replay_clears: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & $past(pend & ~m_eff)) == '0));

  a_r9_pend_needs_use: assert property (@(posedge clk) disable iff (!rst_n)
    (pend & zero_cnt) == '0);

  a_r8_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (&vmask && pend == '0 && !cfg_en && !cfg_fm && !msg_valid));
endmodule

// File: tb/msix_unit_tb.sv
module msix_unit_tb_top;
  localparam int NVEC = 8;
  localparam int AW = $clog2(4*NVEC);
  localparam int VW = $clog2(NVEC) + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic reg_wr = 1'b0, reg_pba = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic irq_req = 1'b0;
  logic [VW-1:0] irq_vec = '0;
  logic use_cmd = 1'b0, unuse_cmd = 1'b0;
  logic [VW-1:0] use_vec = '0;
  logic msg_valid, msg_ready = 1'b1;
  logic [63:0] msg_addr;
  logic [31:0] msg_data;
  logic intx_in = 1'b1;
  logic intx_out;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0, stall_on = 0;
  logic [95:0] expq[$];

  always #10 clk = ~clk;

  msix_unit #(.NVEC(NVEC), .CNTW(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .reg_wr(reg_wr), .reg_pba(reg_pba),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_req(irq_req), .irq_vec(irq_vec), .use_cmd(use_cmd),
    .unuse_cmd(unuse_cmd), .use_vec(use_vec), .msg_valid(msg_valid),
    .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data),
    .intx_in(intx_in), .intx_out(intx_out));

  function automatic logic [95:0] entry(int v);
    return {32'(v), 32'hFEE0_0000 + 32'(v*16), 32'h100 + 32'(v)};
  endfunction

  task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic twr(logic pba, int addr, logic [31:0] d);
    @(posedge clk); #2;
    reg_wr = 1'b1; reg_pba = pba; reg_addr = AW'(addr); reg_wdata = d;
    @(posedge clk); #2;
    reg_wr = 1'b0; reg_pba = 1'b0;
  endtask

  task automatic trd(logic pba, int addr, output logic [31:0] d);
    @(posedge clk); #2;
    reg_pba = pba; reg_addr = AW'(addr);
    @(negedge clk);
    d = reg_rdata;
    #1 reg_pba = 1'b0;
  endtask

  task automatic cwr(logic [15:0] d);
    @(posedge clk); #2;
    cfg_we = 1'b1; cfg_wdata = d;
    @(posedge clk); #2;
    cfg_we = 1'b0;
  endtask

  task automatic irq(int v);
    @(posedge clk); #2;
    irq_req = 1'b1; irq_vec = VW'(v);
    @(posedge clk); #2;
    irq_req = 1'b0;
  endtask

  task automatic usecmd(int v, bit up);
    @(posedge clk); #2;
    use_vec = VW'(v); use_cmd = up; unuse_cmd = !up;
    @(posedge clk); #2;
    use_cmd = 1'b0; unuse_cmd = 1'b0;
  endtask

  // ready driver: stall pattern when enabled
  initial forever begin
    @(posedge clk); #2;
    cyc++;
    msg_ready = stall_on ? (cyc % 3 != 0) : 1'b1;
  end

  // monitor / scoreboard
  initial begin
    bit prev_stall = 0;
    logic [95:0] prev = '0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (prev_stall) begin
          checks++;
          if (!msg_valid || {msg_addr, msg_data} !== prev) begin
            fails++;
            $display("FAIL R11: got v=%b %h expected held %h", msg_valid, {msg_addr, msg_data}, prev);
          end
        end
        prev_stall = msg_valid && !msg_ready;
        prev = {msg_addr, msg_data};
        if (msg_valid && msg_ready) begin
          checks++;
          if (expq.size() == 0) begin
            fails++;
            $display("FAIL R4/R6: got unexpected message %h expected none", {msg_addr, msg_data});
          end else begin
            logic [95:0] e;
            e = expq.pop_front();
            if ({msg_addr, msg_data} !== e) begin
              fails++;
              $display("FAIL R5/R10: got %h expected %h", {msg_addr, msg_data}, e);
            end
          end
        end
      end
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    tick(4);
    rst_n = 1'b1;
    tick(1);
    // R8, R3, R12 reset state
    chk("R3", 64'(cfg_rdata), 64'h0007);
    trd(0, 4*3+3, d); chk("R8", 64'(d), 64'h1);
    trd(0, 4*3+0, d); chk("R8", 64'(d), 64'h0);
    trd(1, 0, d);     chk("R8", 64'(d), 64'h0);
    chk("R12", 64'(intx_out), 64'h1);

    for (int v = 0; v < NVEC; v++) begin
      logic [95:0] e;
      e = entry(v);
      twr(0, 4*v+0, e[63:32]);
      twr(0, 4*v+1, e[95:64]);
      twr(0, 4*v+2, e[31:0]);
    end
    trd(0, 4*2+2, d); chk("R1", 64'(d), 64'h102);
    trd(0, 4*5+1, d); chk("R1", 64'(d), 64'h5);

    for (int v = 0; v < NVEC-1; v++) usecmd(v, 1);
    cwr(16'h8000);
    tick(1);
    chk("R12", 64'(intx_out), 64'h0);
    chk("R3", 64'(cfg_rdata), 64'h8007);

    // R6: masked vector goes pending
    irq(1);
    trd(1, 0, d); chk("R6", 64'(d), 64'h2);
    // R7: per-vector unmask releases it
    expq.push_back(entry(1));
    twr(0, 4*1+3, 32'h0);
    tick(8);
    trd(1, 0, d); chk("R7", 64'(d), 64'h0);
    chk("R7", 64'(expq.size()), 64'h0);

    for (int v = 0; v < NVEC; v++) twr(0, 4*v+3, (v == NVEC-1) ? 32'hFFFF_FFFE : 32'h0);
    trd(0, 4*(NVEC-1)+3, d); chk("R1", 64'(d), 64'h0);

    // R5 unmasked request
    expq.push_back(entry(3));
    irq(3);
    tick(6);
    chk("R5", 64'(expq.size()), 64'h0);

    // R4 unused and out-of-range
    irq(NVEC-1);
    irq(NVEC);
    tick(6);
    trd(1, 0, d); chk("R4", 64'(d), 64'h0);

    // R2 pending array writes ignored
    twr(1, 0, 32'hFFFF_FFFF);
    trd(1, 0, d); chk("R2", 64'(d), 64'h0);

    // R10, R11: function mask, then release in order under stalls
    cwr(16'hC000);
    irq(5); irq(2); irq(6);
    trd(1, 0, d); chk("R6", 64'(d), 64'h64);
    stall_on = 1;
    expq.push_back(entry(2));
    expq.push_back(entry(5));
    expq.push_back(entry(6));
    cwr(16'h8000);
    tick(20);
    chk("R10", 64'(expq.size()), 64'h0);
    trd(1, 0, d); chk("R7", 64'(d), 64'h0);
    stall_on = 0;

    // R6 with enable clear, R7 on enable
    cwr(16'h0000);
    irq(0);
    trd(1, 0, d); chk("R6", 64'(d), 64'h1);
    expq.push_back(entry(0));
    cwr(16'h8000);
    tick(8);
    chk("R7", 64'(expq.size()), 64'h0);

    // R9 use counting
    usecmd(4, 1);
    cwr(16'hC000);
    irq(4);
    usecmd(4, 0);
    trd(1, 0, d); chk("R9", 64'(d), 64'h10);
    usecmd(4, 0);
    trd(1, 0, d); chk("R9", 64'(d), 64'h0);
    usecmd(4, 0);
    usecmd(4, 1);
    cwr(16'h8000);
    tick(6);
    expq.push_back(entry(4));
    irq(4);
    tick(8);
    chk("R9", 64'(expq.size()), 64'h0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule